// File: doc/BRIEF.md
# Conversion Window Monitor with Early Out-of-Range Decision

This block watches a successive-approximation conversion as it resolves, one bit per strobe, most significant bit first. It holds no limits of its own: an upper and a lower 8-bit bound come in from the configuration registers. A mode input chooses whether the block raises its boundary event when a finished result falls within those bounds or when it falls beyond them. An enable input gates the whole check.

When the out-of-range mode is selected, the block does not always wait for the last bit. As soon as the top four bits are final, it compares that nibble with the top nibbles of both bounds. If that nibble alone proves the result lies beyond a bound, the event is raised at once. If it does not, the decision falls to a full 8-bit compare when the conversion completes. Each conversion raises at most one event. The channel index given with the strobe selects a sticky flag, and software clears that flag by writing a one to it.

Top module: `bnd_watch`

## Requirements
- R1: In inside mode (`outside_sel`=0), a `conv_done` strobe whose `part_res` satisfies `lim_lo` <= result <= `lim_hi` makes `bnd_irq` high for exactly the next cycle. Both bounds are inclusive.
- R2: In outside mode (`outside_sel`=1), an event is raised at completion only when the result is strictly greater than `lim_hi` or strictly less than `lim_lo`. A result equal to either bound raises none.
- R3: While `bnd_en` is 0, no strobe raises `bnd_irq` and no flag in `bnd_flags` is set.
- R4: In outside mode, a `bit_vld` strobe with `bit_pos`=4 means `part_res[7:4]` is final. If that nibble is greater than `lim_hi[7:4]` or less than `lim_lo[7:4]`, `bnd_irq` is high in the next cycle, before `conv_done`.
- R5: If that nibble equals a bound's nibble, or lies between the two bound nibbles, no early event is raised, and the full 8-bit compare of R2 decides at `conv_done`.
- R6: A conversion that raised an early event raises no second event at its `conv_done`.
- R7: In inside mode, a `bit_vld` strobe never raises an event, whatever the nibble. The decision is made only at `conv_done`.
- R8: Every event sets bit `chan` of `bnd_flags`, where `chan` is the value sampled with the strobe that caused the event. The flag is visible in the same cycle as `bnd_irq`.
- R9: A one in bit k of `clr_w1c` clears flag k at the next edge, and a zero leaves it alone. If an event sets flag k in the same cycle that `clr_w1c[k]` is high, the flag ends up set.
- R10: After reset, `bnd_irq` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bnd_en | input | 1 | Enables the boundary check |
| outside_sel | input | 1 | 1: event when outside the bounds; 0: event when inside |
| lim_hi | input | 8 | Upper bound |
| lim_lo | input | 8 | Lower bound |
| bit_vld | input | 1 | One bit of the conversion has just resolved |
| bit_pos | input | 3 | Position of that bit (7 = MSB) |
| part_res | input | 8 | Partial or, with conv_done, final result |
| conv_done | input | 1 | Conversion complete; part_res is final |
| chan | input | 2 | Channel of the conversion in progress |
| clr_w1c | input | 4 | Write-one-to-clear mask for the flags |
| bnd_irq | output | 1 | One-cycle boundary event pulse |
| bnd_flags | output | 4 | Sticky per-channel event flags |

## Verification
The assertions check four properties on every cycle. A disabled check leaves the next cycle quiet. An inside-mode bit strobe never produces an event. An early decision always produces a pulse, and a conversion already decided early stays silent at completion. Finally, flags rise only alongside an event and only at the sampled channel. The bench's scenarios are needed for the numeric side: the inclusive and strict bound cases, the nibble-equality deferral, the channel-to-flag mapping across all four channels, and the clear-versus-set race.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_EARLY = 2'd1,
    SRC_FINAL = 2'd2
  } bnd_src_e;
endpackage

// File: rtl/bnd_cmp.sv
module bnd_cmp #(
  parameter int RES_W   = 8,
  parameter int EARLY_W = 4
) (
  input  logic [RES_W-1:0] res,
  input  logic [RES_W-1:0] hi,
  input  logic [RES_W-1:0] lo,
  output logic             full_in,
  output logic             full_out,
  output logic             early_out
);
  localparam int TOP = RES_W - 1;
  localparam int BOT = RES_W - EARLY_W;

  function automatic logic in_window(input logic [RES_W-1:0] v,
                                     input logic [RES_W-1:0] h,
                                     input logic [RES_W-1:0] l);
    return (v >= l) && (v <= h);
  endfunction

  function automatic logic beyond(input logic [RES_W-1:0] v,
                                  input logic [RES_W-1:0] h,
                                  input logic [RES_W-1:0] l);
    return (v > h) || (v < l);
  endfunction

  function automatic logic nib_beyond(input logic [EARLY_W-1:0] v,
                                      input logic [EARLY_W-1:0] h,
                                      input logic [EARLY_W-1:0] l);
    return (v > h) || (v < l);
  endfunction

  always_comb begin
    full_in   = in_window(res, hi, lo);
    full_out  = beyond(res, hi, lo);
    early_out = nib_beyond(res[TOP:BOT], hi[TOP:BOT], lo[TOP:BOT]);
  end
endmodule

// File: rtl/bnd_early_ctl.sv
module bnd_early_ctl #(
  parameter int RES_W   = 8,
  parameter int EARLY_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       armed,
  input  logic                       bit_vld,
  input  logic [$clog2(RES_W)-1:0]   bit_pos,
  input  logic                       conv_done,
  input  logic                       nib_beyond,
  output logic                       early_ev,
  output logic                       early_hit
);
  localparam int                     EARLY_POS = RES_W - EARLY_W;
  localparam logic [$clog2(RES_W)-1:0] POS_K   = EARLY_POS[$clog2(RES_W)-1:0];

  logic hit_q;

  always_comb begin
    early_ev = armed && bit_vld && (bit_pos == POS_K) && !hit_q && nib_beyond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hit_q <= 1'b0;
    else if (conv_done) hit_q <= 1'b0;
    else if (early_ev)  hit_q <= 1'b1;
  end

  assign early_hit = hit_q;
endmodule

// File: rtl/bnd_flag_bank.sv
module bnd_flag_bank #(
  parameter int NCH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_vld,
  input  logic [$clog2(NCH)-1:0]   set_idx,
  input  logic [NCH-1:0]           clr_mask,
  output logic [NCH-1:0]           flags
);
  for (genvar k = 0; k < NCH; k++) begin : g_flag
    logic set_k;
    logic q;
    always_comb set_k = set_vld && (set_idx == k[$clog2(NCH)-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= 1'b0;
      else if (set_k)       q <= 1'b1;
      else if (clr_mask[k]) q <= 1'b0;
    end
    assign flags[k] = q;
  end
endmodule

// File: rtl/bnd_watch.sv
module bnd_watch #(
  parameter int RES_W   = 8,
  parameter int EARLY_W = 4,
  parameter int NCH     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bnd_en,
  input  logic                       outside_sel,
  input  logic [RES_W-1:0]           lim_hi,
  input  logic [RES_W-1:0]           lim_lo,
  input  logic                       bit_vld,
  input  logic [$clog2(RES_W)-1:0]   bit_pos,
  input  logic [RES_W-1:0]           part_res,
  input  logic                       conv_done,
  input  logic [$clog2(NCH)-1:0]     chan,
  input  logic [NCH-1:0]             clr_w1c,
  output logic                       bnd_irq,
  output logic [NCH-1:0]             bnd_flags
);
  import bnd_pkg::*;

  logic     full_in_w, full_out_w, nib_beyond_w;
  logic     early_ev_w, early_hit_w, final_ev_w, any_ev_w;
  bnd_src_e src_w;
  logic     irq_q;

  bnd_cmp #(.RES_W(RES_W), .EARLY_W(EARLY_W)) u_cmp (
    .res      (part_res),
    .hi       (lim_hi),
    .lo       (lim_lo),
    .full_in  (full_in_w),
    .full_out (full_out_w),
    .early_out(nib_beyond_w)
  );

  bnd_early_ctl #(.RES_W(RES_W), .EARLY_W(EARLY_W)) u_early (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (bnd_en && outside_sel),
    .bit_vld   (bit_vld),
    .bit_pos   (bit_pos),
    .conv_done (conv_done),
    .nib_beyond(nib_beyond_w),
    .early_ev  (early_ev_w),
    .early_hit (early_hit_w)
  );

  always_comb begin
    final_ev_w = bnd_en && conv_done && !early_hit_w &&
                 (outside_sel ? full_out_w : full_in_w);
    if (early_ev_w)      src_w = SRC_EARLY;
    else if (final_ev_w) src_w = SRC_FINAL;
    else                 src_w = SRC_NONE;
    any_ev_w = (src_w != SRC_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_ev_w;
  end

  bnd_flag_bank #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vld (any_ev_w),
    .set_idx (chan),
    .clr_mask(clr_w1c),
    .flags   (bnd_flags)
  );

  assign bnd_irq = irq_q;
endmodule

// File: rtl/bnd_watch_chk.sv
module bnd_watch_chk #(
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bnd_en,
  input logic                   outside_sel,
  input logic                   bit_vld,
  input logic                   conv_done,
  input logic [$clog2(NCH)-1:0] chan,
  input logic                   early_ev,
  input logic                   early_hit,
  input logic                   bnd_irq,
  input logic [NCH-1:0]         bnd_flags
);
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_en |=> !bnd_irq);

  a_r7_no_early_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !conv_done && !outside_sel) |=> !bnd_irq);

  a_r4_early_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    early_ev |=> bnd_irq);

  a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    (early_hit && conv_done && !bit_vld) |=> !bnd_irq);

  a_r8_flag_at_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_en && early_ev) |=> bnd_flags[$past(chan)]);

  a_r8_rise_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bnd_flags & ~$past(bnd_flags))) |-> bnd_irq);
endmodule

bind bnd_watch bnd_watch_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bnd_en     (bnd_en),
  .outside_sel(outside_sel),
  .bit_vld    (bit_vld),
  .conv_done  (conv_done),
  .chan       (chan),
  .early_ev   (early_ev_w),
  .early_hit  (early_hit_w),
  .bnd_irq    (bnd_irq),
  .bnd_flags  (bnd_flags)
);

// File: tb/test_bnd_watch.sv
module test_bnd_watch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bnd_en = 1'b0, outside_sel = 1'b0;
  logic [7:0] lim_hi = 8'h00, lim_lo = 8'h00, part_res = 8'h00;
  logic       bit_vld = 1'b0, conv_done = 1'b0;
  logic [2:0] bit_pos = 3'd0;
  logic [1:0] chan = 2'd0;
  logic [3:0] clr_w1c = 4'h0;
  logic       bnd_irq;
  logic [3:0] bnd_flags;

  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_flags = 4'h0;
  bit finished = 0;

  always #5 clk = ~clk;

  bnd_watch i_bnd_watch (
    .clk(clk), .rst_n(rst_n), .bnd_en(bnd_en), .outside_sel(outside_sel),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .bit_vld(bit_vld), .bit_pos(bit_pos),
    .part_res(part_res), .conv_done(conv_done), .chan(chan),
    .clr_w1c(clr_w1c), .bnd_irq(bnd_irq), .bnd_flags(bnd_flags)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input string req, input logic [1:0] ch,
                          input logic [7:0] res, input logic [3:0] clr_at_done);
    int e_cnt = 0, f_cnt = 0, stray = 0;
    bit exp_e, exp_f;
    exp_e = bnd_en && outside_sel &&
            ((res[7:4] > lim_hi[7:4]) || (res[7:4] < lim_lo[7:4]));
    if (!bnd_en || exp_e)  exp_f = 0;
    else if (outside_sel)  exp_f = !((res <= lim_hi) && (res >= lim_lo));
    else                   exp_f = (res <= lim_hi) && (res >= lim_lo);
    chan = ch;
    for (int p = 7; p >= 0; p--) begin
      bit_vld  = 1'b1;
      bit_pos  = 3'(p);
      part_res = res & (8'hFF << p);
      @(negedge clk);
      bit_vld = 1'b0;
      if (bnd_irq) begin
        if (p == 4) e_cnt++; else stray++;
      end
    end
    conv_done = 1'b1;
    part_res  = res;
    clr_w1c   = clr_at_done;
    @(negedge clk);
    conv_done = 1'b0;
    clr_w1c   = 4'h0;
    if (bnd_irq) f_cnt++;
    exp_flags = exp_flags & ~clr_at_done;
    if (exp_e || exp_f) exp_flags[ch] = 1'b1;
    @(negedge clk);
    if (bnd_irq) stray++;
    check({req, " early"}, e_cnt, int'(exp_e));
    check({req, " final"}, f_cnt, int'(exp_f));
    check({req, " stray"}, stray, 0);
    check({req, " flags R8"}, int'(bnd_flags), int'(exp_flags));
  endtask

  task automatic clear(input string req, input logic [3:0] m);
    clr_w1c = m;
    @(negedge clk);
    clr_w1c = 4'h0;
    exp_flags = exp_flags & ~m;
    check(req, int'(bnd_flags), int'(exp_flags));
  endtask

  task automatic t_reset;
    check("R10 irq", int'(bnd_irq), 0);
    check("R10 flags", int'(bnd_flags), 0);
  endtask

  task automatic t_inside;
    bnd_en = 1; outside_sel = 0; lim_hi = 8'hA0; lim_lo = 8'h40;
    run_conv("R1 eq lo", 2'd0, 8'h40, 4'h0);
    run_conv("R1 eq hi", 2'd1, 8'hA0, 4'h0);
    run_conv("R1 above", 2'd2, 8'hA1, 4'h0);
    run_conv("R7 high nibble", 2'd3, 8'hF0, 4'h0);
    run_conv("R7 low nibble", 2'd3, 8'h10, 4'h0);
  endtask

  task automatic t_outside;
    clear("R9 clear all", 4'hF);
    outside_sel = 1;
    run_conv("R5 defer above", 2'd2, 8'hA1, 4'h0);
    run_conv("R2 eq hi", 2'd0, 8'hA0, 4'h0);
    run_conv("R2 eq lo", 2'd0, 8'h40, 4'h0);
    run_conv("R5 defer below", 2'd1, 8'h45, 4'h0);
    run_conv("R4 R6 early low", 2'd3, 8'h3F, 4'h0);
    run_conv("R4 R6 early high", 2'd0, 8'hB0, 4'h0);
    run_conv("R5 mid nibble", 2'd1, 8'h77, 4'h0);
  endtask

  task automatic t_disabled;
    clear("R9 clear all", 4'hF);
    bnd_en = 0;
    run_conv("R3 out early", 2'd1, 8'hF0, 4'h0);
    outside_sel = 0;
    run_conv("R3 in", 2'd2, 8'h50, 4'h0);
  endtask

  task automatic t_w1c;
    bnd_en = 1; outside_sel = 0;
    run_conv("R8 ch1", 2'd1, 8'h50, 4'h0);
    run_conv("R8 ch3", 2'd3, 8'h60, 4'h0);
    clear("R9 partial", 4'b0010);
    clear("R9 zero mask", 4'h0);
    run_conv("R9 set wins", 2'd3, 8'h60, 4'b1000);
    check("R9 set wins bit", int'(bnd_flags[3]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_inside();
    t_outside();
    t_disabled();
    t_w1c();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule